// File: doc/BRIEF.md
# Branch Target Buffer

This block holds a small direct-mapped table of branch addresses and the addresses those branches jumped to. Each fetch cycle the front end sends its fetch PC to this block at the same time as it sends it to instruction memory. If a valid entry's stored branch address matches, the block raises a hit and returns the stored target in the same cycle, so fetch can redirect at once. Only taken branches are kept, so an entry being present already means "predict taken".

When a branch resolves, a resolve port reports four things: its PC, whether it was a taken branch, whether it hit in this table at fetch, and its actual next PC. The table then changes in one of three ways:
- A taken branch that missed is written in as a new entry.
- A hit that was wrong, either because the branch was not taken or because it went to a different target, removes its entry. A one-cycle mispredict flag tells fetch to restart at the correct address.
- A hit that was correct leaves everything as it is.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every entry is invalid. No fetch PC hits, and `mispredict` is low.
- R2: `fetchHit` is high in the same cycle as `fetchPc` only when the selected entry is valid and its stored tag equals the tag of `fetchPc`. While it is high, `fetchTarget` carries that entry's stored target.
- R3: A resolve with `resValid=1`, `resTaken=1` and `resHit=0` writes its PC tag and `resNextPc` into the entry. Fetches of that PC hit from the next cycle on.
- R4: A resolve with `resHit=0` and `resTaken=0` leaves the table unchanged and keeps `mispredict` low.
- R5: A resolve with `resHit=1` and `resTaken=0` raises `mispredict` for the cycle after the resolve. It also invalidates the matching entry.
- R6: A resolve with `resHit=1`, `resTaken=1` and a `resNextPc` different from the stored target raises `mispredict` and invalidates the matching entry.
- R7: A resolve with `resHit=1`, `resTaken=1` and a `resNextPc` equal to the stored target keeps `mispredict` low. The entry is unchanged.
- R8: An allocation replaces whatever entry already sits at the same index. The earlier branch at that index then misses.
- R9: The index is PC bits [ALIGN_W+IDX_W-1:ALIGN_W], which are bits [5:2] by default. The tag is all bits above the index. The ALIGN_W lowest bits play no part in lookup or update.
- R10: A resolve with `resHit=1` whose PC no longer matches the entry at its index raises `mispredict`. The other branch's entry at that index is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | PC_W | PC being fetched this cycle |
| fetchHit | output | 1 | Valid entry matches `fetchPc` |
| fetchTarget | output | PC_W | Predicted next PC on a hit |
| resValid | input | 1 | Resolve report present this cycle |
| resPc | input | PC_W | PC of the resolving instruction |
| resTaken | input | 1 | Instruction was a taken branch |
| resHit | input | 1 | Instruction hit in this table at fetch |
| resNextPc | input | PC_W | Actual next PC of the instruction |
| mispredict | output | 1 | Hit was wrong; fetch must restart (one cycle after the resolve) |

## Verification
The bench sweeps all sixteen indices of the default table with tags chosen per index, so a wrong index or tag slice shows up as a hit in the wrong place. Lookups are repeated with the alignment bits set to every value and with a foreign tag, which separates a correct tag compare from one that ignores or includes the wrong bits. Resolve patterns cover these cases:
- a taken miss
- a not-taken miss
- a correct hit
- a hit that was not taken
- a hit with a wrong target
- an aliasing allocation
- a stale hit

Each pattern is compared against a table model kept in the bench, so allocation, deletion, no-change and overwrite are each told apart by the lookups that follow them.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Strobes passed from control to the table datapath
  typedef struct packed {
    logic alloc;   // write a new entry at the resolve index
    logic evict;   // invalidate the resolve index if its tag still matches
    logic flag;    // hit turned out wrong
  } btbStrobes_t;
endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int ALIGN_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   fetchPc,
  output logic              fetchHit,
  output logic [PC_W-1:0]   fetchTarget,
  input  logic [PC_W-1:0]   resPc,
  input  logic [PC_W-1:0]   resNextPc,
  input  btbStrobes_t       strobes,
  output logic              resMatch,
  output logic              resTargetOk
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

  logic [DEPTH-1:0] validQ;
  logic [TAG_W-1:0] tagQ [DEPTH];
  logic [PC_W-1:0]  tgtQ [DEPTH];

  logic [IDX_W-1:0] fetchIdx, resIdx;
  logic [TAG_W-1:0] fetchTag, resTag;

  assign fetchIdx = fetchPc[ALIGN_W +: IDX_W];
  assign fetchTag = fetchPc[PC_W-1 -: TAG_W];
  assign resIdx   = resPc[ALIGN_W +: IDX_W];
  assign resTag   = resPc[PC_W-1 -: TAG_W];

  // Lookup: same-cycle read, like a cache tag compare
  always_comb begin
    fetchHit    = validQ[fetchIdx] && (tagQ[fetchIdx] == fetchTag);
    fetchTarget = tgtQ[fetchIdx];
  end

  // Resolve-side compare against the current entry
  always_comb begin
    resMatch    = validQ[resIdx] && (tagQ[resIdx] == resTag);
    resTargetOk = (tgtQ[resIdx] == resNextPc);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobes.alloc) begin
      validQ[resIdx] <= 1'b1;
    end else if (strobes.evict && resMatch) begin
      validQ[resIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.alloc) begin
      tagQ[resIdx] <= resTag;
      tgtQ[resIdx] <= resNextPc;
    end
  end

  assert_alloc_visible_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.alloc |=> validQ[$past(resIdx)] && tagQ[$past(resIdx)] == $past(resTag)
                      && tgtQ[$past(resIdx)] == $past(resNextPc));

  assert_evict_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evict && resMatch) |=> !validQ[$past(resIdx)]);

  assert_quiet_no_change_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.alloc && !strobes.evict) |=> $stable(validQ));

  assert_stale_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evict && !resMatch && !strobes.alloc) |=> $stable(validQ));
endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        resValid,
  input  logic        resTaken,
  input  logic        resHit,
  input  logic        resMatch,
  input  logic        resTargetOk,
  output btbStrobes_t strobes,
  output logic        mispredict
);
  logic predictGood;
  logic mispredictQ;

  assign predictGood = resTaken && resMatch && resTargetOk;

  always_comb begin
    strobes.alloc = resValid && resTaken && !resHit;
    strobes.flag  = resValid && resHit && !predictGood;
    strobes.evict = strobes.flag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) mispredictQ <= 1'b0;
    else       mispredictQ <= strobes.flag;
  end

  assign mispredict = mispredictQ;

  assert_alloc_evict_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.alloc && strobes.evict));

  assert_not_taken_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resHit && !resTaken) |=> mispredict);

  assert_good_hit_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resHit && resTaken && resMatch && resTargetOk) |=> !mispredict);

  assert_miss_never_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!resValid || !resHit) |=> !mispredict);
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int ALIGN_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            fetchHit,
  output logic [PC_W-1:0] fetchTarget,
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  input  logic            resHit,
  input  logic [PC_W-1:0] resNextPc,
  output logic            mispredict
);
  btbStrobes_t strobes;
  logic resMatch, resTargetOk;

  btb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .resValid(resValid), .resTaken(resTaken), .resHit(resHit),
    .resMatch(resMatch), .resTargetOk(resTargetOk),
    .strobes(strobes), .mispredict(mispredict)
  );

  btb_datapath #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .fetchPc(fetchPc), .fetchHit(fetchHit), .fetchTarget(fetchTarget),
    .resPc(resPc), .resNextPc(resNextPc), .strobes(strobes),
    .resMatch(resMatch), .resTargetOk(resTargetOk)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> !mispredict && !fetchHit);
endmodule

// File: tb/branch_target_buffer_tb.sv
module branch_target_buffer_tb;
  localparam int PC_W = 32, IDX_W = 4, ALIGN_W = 2;
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] fetchPc = '0, resPc = '0, resNextPc = '0;
  logic resValid = 1'b0, resTaken = 1'b0, resHit = 1'b0;
  logic fetchHit, mispredict;
  logic [PC_W-1:0] fetchTarget;

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench table model
  bit              mV   [DEPTH];
  logic [TAG_W-1:0] mTag [DEPTH];
  logic [PC_W-1:0]  mTgt [DEPTH];

  always #2 clk = ~clk;

  branch_target_buffer #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_dut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .fetchHit(fetchHit),
    .fetchTarget(fetchTarget), .resValid(resValid), .resPc(resPc),
    .resTaken(resTaken), .resHit(resHit), .resNextPc(resNextPc),
    .mispredict(mispredict)
  );

  function automatic logic [PC_W-1:0] mkPc(int tag, int idx, int low);
    logic [TAG_W-1:0] t = TAG_W'(tag);
    logic [IDX_W-1:0] i = IDX_W'(idx);
    logic [ALIGN_W-1:0] l = ALIGN_W'(low);
    return {t, i, l};
  endfunction

  task automatic chk(string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic look(logic [PC_W-1:0] pc, string req);
    int i = int'(pc[ALIGN_W +: IDX_W]);
    bit eh;
    fetchPc = pc;
    #1;
    eh = mV[i] && (mTag[i] == pc[PC_W-1 -: TAG_W]);
    chk(req, PC_W'(fetchHit), PC_W'(eh), "hit");
    if (eh) chk(req, fetchTarget, mTgt[i], "target");
  endtask

  task automatic resolve(logic [PC_W-1:0] pc, bit taken, bit hit,
                         logic [PC_W-1:0] nxt, string req);
    int i = int'(pc[ALIGN_W +: IDX_W]);
    bit match = mV[i] && (mTag[i] == pc[PC_W-1 -: TAG_W]);
    bit good = taken && match && (mTgt[i] == nxt);
    bit ef = hit && !good;
    @(negedge clk);
    resValid = 1; resPc = pc; resTaken = taken; resHit = hit; resNextPc = nxt;
    @(negedge clk);
    resValid = 0; resTaken = 0; resHit = 0;
    #1;
    chk(req, PC_W'(mispredict), PC_W'(ef), "mispredict");
    if (taken && !hit) begin
      mV[i] = 1; mTag[i] = pc[PC_W-1 -: TAG_W]; mTgt[i] = nxt;
    end else if (ef && match) begin
      mV[i] = 0;
    end
  endtask

  function automatic logic [PC_W-1:0] tgtOf(int i);
    return 32'h1000_0000 + PC_W'(i) * 32'h40;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mV[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1", PC_W'(mispredict), 0, "mispredict after reset");
    for (int i = 0; i < DEPTH; i++) look(mkPc(i * 3 + 1, i, 0), "R1");

    // R3: allocate every index
    for (int i = 0; i < DEPTH; i++) resolve(mkPc(i * 3 + 1, i, 0), 1, 0, tgtOf(i), "R3");
    // R2, R9: every index, every alignment value, own and foreign tags
    for (int i = 0; i < DEPTH; i++)
      for (int l = 0; l < (1 << ALIGN_W); l++) begin
        @(negedge clk);
        look(mkPc(i * 3 + 1, i, l), "R9");
        look(mkPc(i * 3 + 2, i, l), "R2");
      end

    // R4: not-taken miss at idx 0 with a new tag, changes nothing
    resolve(mkPc(77, 0, 0), 0, 0, 32'hdead_0000, "R4");
    @(negedge clk); look(mkPc(1, 0, 0), "R4"); look(mkPc(77, 0, 0), "R4");

    // R7: correct hit on idx 1
    resolve(mkPc(4, 1, 0), 1, 1, tgtOf(1), "R7");
    @(negedge clk); look(mkPc(4, 1, 0), "R7");
    chk("R7", PC_W'(fetchHit), 1, "entry kept");

    // R5: hit not taken on idx 2
    resolve(mkPc(7, 2, 0), 0, 1, mkPc(7, 2, 0) + 4, "R5");
    @(negedge clk); look(mkPc(7, 2, 0), "R5");
    chk("R5", PC_W'(fetchHit), 0, "entry deleted");

    // R6: hit taken to a different target on idx 3
    resolve(mkPc(10, 3, 0), 1, 1, 32'h2222_0000, "R6");
    @(negedge clk); look(mkPc(10, 3, 0), "R6");
    chk("R6", PC_W'(fetchHit), 0, "entry deleted");

    // R8: aliasing allocation at idx 4
    resolve(mkPc(500, 4, 0), 1, 0, 32'h3333_0000, "R8");
    @(negedge clk); look(mkPc(13, 4, 0), "R8"); look(mkPc(500, 4, 0), "R8");
    chk("R8", fetchTarget, 32'h3333_0000, "new target");

    // R10: stale hit for old tag at idx 4
    resolve(mkPc(13, 4, 0), 1, 1, tgtOf(4), "R10");
    @(negedge clk); look(mkPc(500, 4, 0), "R10");
    chk("R10", PC_W'(fetchHit), 1, "other entry kept");

    // Final sweep: every entry matches the model
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      look(mkPc(i * 3 + 1, i, 0), "R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule